// File: doc/BRIEF.md
# Control Register Write Guard

This block holds the one-byte configuration and status register of a serial EEPROM supervisor and decides, byte by byte, whether a write coming from the serial front end may proceed. It sees an already decoded transaction stream: an address, a data byte, a write strobe for each data byte, a read strobe and an end-of-transaction (stop) indication, plus the external write-protect pin. For every written data byte it answers with an acknowledge. For array addresses it also raises a permit signal that the array controller uses. Register updates take effect at the stop. A committed update of the non-volatile fields issues a one-cycle start pulse and holds the unit busy for a programmable number of cycles.

Two volatile latches gate writes. The general write latch must be set before anything except the latch-setting byte itself is accepted. The second latch must be set before the non-volatile fields may change. A three-bit block-protect code locks either an upper quarter, an upper half or the whole array, or a first-page range of 64, 128, 256 or 512 bytes. When the protect pin and the stored protect-enable bit are both high, the non-volatile fields are frozen. In that state the protect-enable bit cannot be cleared until the pin drops.

Top module: `ctrl_reg_guard`

## Requirements
- R1: After reset the register reads 8'h00: both latches clear, protect-enable 0, watchdog select 00, block-protect code 000.
- R2: While the write latch is 0, a write to the register address (all address bits 1) is acknowledged only for byte 8'h02. Every other register byte and every array write gets no acknowledge and no permit.
- R3: With the second latch at 0, register byte 8'h02 sets the write latch. Byte 8'h00 clears both latches. Byte 8'h06 sets both latches. The latter two need the write latch already set. Each change takes effect at the following stop, and none of them raises the start pulse.
- R4: A read strobe at the register address gives, on the next cycle, rdata_o = {protect-enable, watchdog[1:0], block-protect[1:0], second latch, write latch, block-protect[2]} (bit 7 down to bit 0).
- R5: While the second latch is 1, any register byte is a non-volatile write of bits 7:3 and 0. It is acknowledged, and at the stop it updates those fields, clears the second latch and pulses nv_start_o for one cycle. Without the second latch, any byte other than 8'h00, 8'h02 or 8'h06 is not acknowledged and changes nothing.
- R6: Block-protect code 000 protects nothing. Code 001 protects 3000h-3FFFh, 010 protects 2000h-3FFFh, 011 the whole array, 100 000h-03Fh, 101 000h-07Fh, 110 000h-0FFh and 111 000h-1FFh. An array write to a protected address gets no acknowledge and no permit. Any other array write with the write latch set gets both.
- R7: For array writes only the low 14 address bits count, so an address that differs only in bits 15:14 is treated the same.
- R8: With wp_i = 1 and protect-enable = 1, non-volatile writes get no acknowledge and leave every register field unchanged, so protect-enable stays 1. Setting the second latch and writing unprotected array addresses still work. With either of the two signals at 0, non-volatile writes are accepted.
- R9: For NV_CYCLES cycles after the start pulse, every write gets no acknowledge. Register reads still return the current contents.
- R10: Only one register byte is accepted per transaction. A further register write before the stop gets no acknowledge.
- R11: wd_sel_o always equals the stored watchdog select field.
- R12: ack_o and arr_wr_ok_o appear on the cycle after the write strobe and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| addr_i | input | 16 | Byte address of the current data byte or read |
| wdata_i | input | 8 | Data byte being written |
| wr_i | input | 1 | One-cycle strobe per written data byte |
| rd_i | input | 1 | One-cycle read strobe |
| stop_i | input | 1 | End of the current transaction |
| wp_i | input | 1 | Write-protect pin level |
| rdata_o | output | 8 | Register contents from the last register read |
| ack_o | output | 1 | Data byte acknowledge, one cycle after wr_i |
| arr_wr_ok_o | output | 1 | Array write permitted, one cycle after wr_i |
| nv_start_o | output | 1 | One-cycle start of a non-volatile register write |
| wd_sel_o | output | 2 | Watchdog period select (00 longest, 11 off) |

## Verification
On every cycle, assertions check several rules: no acknowledge without the write latch or during the busy window, no second register byte in a transaction, no field change without a start pulse, frozen fields while the pin and protect-enable are both high, a fully locked array under code 011, and acknowledges that follow a write strobe. The exact boundaries of each of the eight protect ranges, the aliasing of the upper address bits, the register read layout and the sequences of latch commands can only be shown by the bench's scenarios. Those scenarios compare ports against values worked out from the requirements.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    // Register byte commands recognised while the second latch is clear
    localparam logic [7:0] CMD_SET_WEL  = 8'h02;
    localparam logic [7:0] CMD_CLR_WEL  = 8'h00;
    localparam logic [7:0] CMD_SET_RWEL = 8'h06;

    // Non-volatile fields of the register
    typedef struct packed {
        logic       wpen;
        logic [1:0] wd;
        logic [2:0] bp;
    } nvcfg_t;

    // Register update waiting for the stop
    typedef enum logic [2:0] {
        PK_NONE     = 3'd0,
        PK_SET_WEL  = 3'd1,
        PK_CLR_WEL  = 3'd2,
        PK_SET_RWEL = 3'd3,
        PK_NV       = 3'd4
    } pend_e;

    typedef struct packed {
        nvcfg_t     cfg;
        nvcfg_t     pcfg;
        pend_e      pk;
        logic       wel;
        logic       rwel;
        logic       ack;
        logic       arr_ok;
        logic       nv_start;
        logic [7:0] rdata;
    } guard_st_t;

    function automatic logic [7:0] pack_reg(nvcfg_t c, logic rwel, logic wel);
        return {c.wpen, c.wd, c.bp[1:0], rwel, wel, c.bp[2]};
    endfunction

    function automatic nvcfg_t unpack_cfg(logic [7:0] b);
        nvcfg_t c;
        c.wpen = b[7];
        c.wd   = b[6:5];
        c.bp   = {b[0], b[4:3]};
        return c;
    endfunction

endpackage

// File: rtl/cwp_block_decode.sv
module cwp_block_decode #(
    parameter int ARR_AW  = 14,
    parameter int PAGE_AW = 6
) (
    input  logic [ARR_AW-1:0] addr_i,
    input  logic [2:0]        bp_i,
    output logic              prot_o
);

    logic [1:0]        upper_q;
    logic [ARR_AW-1:0] page_hi;

    always_comb begin
        upper_q = addr_i[ARR_AW-1:ARR_AW-2];
        // first-page ranges double in size with each step of bp[1:0]
        page_hi = addr_i >> (PAGE_AW + int'(bp_i[1:0]));
        unique case (bp_i)
            3'b000:  prot_o = 1'b0;
            3'b001:  prot_o = (upper_q == 2'b11);
            3'b010:  prot_o = addr_i[ARR_AW-1];
            3'b011:  prot_o = 1'b1;
            default: prot_o = (page_hi == '0);
        endcase
    end

endmodule

// File: rtl/cwp_nv_timer.sv
module cwp_nv_timer #(
    parameter int NV_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(NV_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(NV_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R9: a new cycle is only launched once the previous one has ended
    a_r9_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/ctrl_reg_guard.sv
module ctrl_reg_guard
    import cwp_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ARR_AW    = 14,
    parameter int PAGE_AW   = 6,
    parameter int NV_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic [7:0]        rdata_o,
    output logic              ack_o,
    output logic              arr_wr_ok_o,
    output logic              nv_start_o,
    output logic [1:0]        wd_sel_o
);

    localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};
    localparam guard_st_t         ST_RST   = '0;

    guard_st_t st_d, st_q;
    logic      is_reg;
    logic      hw_lock;
    logic      arr_prot;
    logic      busy;
    logic      commit_nv;
    pend_e     wr_kind;

    cwp_block_decode #(
        .ARR_AW  (ARR_AW),
        .PAGE_AW (PAGE_AW)
    ) u_decode (
        .addr_i (addr_i[ARR_AW-1:0]),
        .bp_i   (st_q.cfg.bp),
        .prot_o (arr_prot)
    );

    cwp_nv_timer #(
        .NV_CYCLES (NV_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_nv),
        .busy_o  (busy)
    );

    assign is_reg  = (addr_i == REG_ADDR);
    assign hw_lock = wp_i & st_q.cfg.wpen;

    always_comb begin
        st_d          = st_q;
        st_d.ack      = 1'b0;
        st_d.arr_ok   = 1'b0;
        st_d.nv_start = 1'b0;
        commit_nv     = 1'b0;
        wr_kind       = PK_NONE;

        // stop applies the update captured earlier in the transaction
        if (stop_i) begin
            unique case (st_q.pk)
                PK_SET_WEL: st_d.wel = 1'b1;
                PK_CLR_WEL: begin
                    st_d.wel  = 1'b0;
                    st_d.rwel = 1'b0;
                end
                PK_SET_RWEL: begin
                    st_d.wel  = 1'b1;
                    st_d.rwel = 1'b1;
                end
                PK_NV: begin
                    if (!hw_lock) begin
                        st_d.cfg      = st_q.pcfg;
                        st_d.rwel     = 1'b0;
                        st_d.nv_start = 1'b1;
                        commit_nv     = 1'b1;
                    end
                end
                default: ;
            endcase
            st_d.pk = PK_NONE;
        end

        if (wr_i) begin
            if (is_reg) begin
                if (!busy && (st_q.pk == PK_NONE) && !stop_i) begin
                    if (st_q.rwel) begin
                        if (!hw_lock) wr_kind = PK_NV;
                    end else if (wdata_i == CMD_SET_WEL) begin
                        wr_kind = PK_SET_WEL;
                    end else if (st_q.wel && (wdata_i == CMD_CLR_WEL)) begin
                        wr_kind = PK_CLR_WEL;
                    end else if (st_q.wel && (wdata_i == CMD_SET_RWEL)) begin
                        wr_kind = PK_SET_RWEL;
                    end
                end
                if (wr_kind != PK_NONE) begin
                    st_d.ack  = 1'b1;
                    st_d.pk   = wr_kind;
                    st_d.pcfg = unpack_cfg(wdata_i);
                end
            end else begin
                st_d.ack    = st_q.wel & ~busy & ~arr_prot;
                st_d.arr_ok = st_q.wel & ~busy & ~arr_prot;
            end
        end

        if (rd_i && is_reg) begin
            st_d.rdata = pack_reg(st_q.cfg, st_q.rwel, st_q.wel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign rdata_o     = st_q.rdata;
    assign ack_o       = st_q.ack;
    assign arr_wr_ok_o = st_q.arr_ok;
    assign nv_start_o  = st_q.nv_start;
    assign wd_sel_o    = st_q.cfg.wd;

    // R2: array writes need the write latch
    a_r2_array_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !is_reg && !st_q.wel) |=> (!ack_o && !arr_wr_ok_o));

    // R2: only the latch-setting byte passes without the write latch
    a_r2_reg_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && is_reg && !st_q.wel && (wdata_i != CMD_SET_WEL)) |=> !ack_o);

    // R5: non-volatile fields change only together with a start pulse
    a_r5_cfg_change_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.cfg) |-> nv_start_o);

    // R6: code 011 locks every array address
    a_r6_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !is_reg && (st_q.cfg.bp == 3'b011)) |=> !arr_wr_ok_o);

    // R8: pin plus protect-enable freezes the non-volatile fields
    a_r8_hw_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_i && st_q.cfg.wpen) |=> $stable(st_q.cfg));

    // R9: nothing is acknowledged during the busy window
    a_r9_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && busy) |=> !ack_o);

    // R9: a start pulse opens the busy window
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        nv_start_o |-> busy);

    // R10: one register byte per transaction
    a_r10_one_reg_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && is_reg && (st_q.pk != PK_NONE)) |=> !ack_o);

    // R12: acknowledges only follow a write strobe
    a_r12_ack_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(wr_i));

    // R12: a permit always comes with an acknowledge
    a_r12_permit_acked: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok_o |-> ack_o);

endmodule

// File: tb/test_ctrl_reg_guard.sv
module test_ctrl_reg_guard;

    localparam int NVC = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr_i;
    logic [7:0]  wdata_i;
    logic        wr_i, rd_i, stop_i, wp_i;
    logic [7:0]  rdata_o;
    logic        ack_o, arr_wr_ok_o, nv_start_o;
    logic [1:0]  wd_sel_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    ctrl_reg_guard #(
        .ADDR_W    (16),
        .ARR_AW    (14),
        .PAGE_AW   (6),
        .NV_CYCLES (NVC)
    ) i_ctrl_reg_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .wr_i        (wr_i),
        .rd_i        (rd_i),
        .stop_i      (stop_i),
        .wp_i        (wp_i),
        .rdata_o     (rdata_o),
        .ack_o       (ack_o),
        .arr_wr_ok_o (arr_wr_ok_o),
        .nv_start_o  (nv_start_o),
        .wd_sel_o    (wd_sel_o)
    );

    function automatic logic prot_model(logic [2:0] bp, logic [15:0] a);
        logic [13:0] x;
        x = a[13:0];
        case (bp)
            3'b000:  return 1'b0;
            3'b001:  return x >= 14'h3000;
            3'b010:  return x >= 14'h2000;
            3'b011:  return 1'b1;
            3'b100:  return x <= 14'h003F;
            3'b101:  return x <= 14'h007F;
            3'b110:  return x <= 14'h00FF;
            default: return x <= 14'h01FF;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(logic [15:0] a, logic [7:0] d, output logic ack, output logic ok);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
        ack = ack_o; ok = arr_wr_ok_o;
    endtask

    task automatic do_stop(output logic nvs);
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        nvs = nv_start_o;
    endtask

    task automatic rd_reg(output logic [7:0] v);
        @(negedge clk);
        addr_i = 16'hFFFF; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        v = rdata_o;
    endtask

    // Needs write latch set and second latch clear on entry
    task automatic set_cfg(logic wpen, logic [1:0] wd, logic [2:0] bp);
        logic a, o, s;
        logic [7:0] v;
        wr_byte(16'hFFFF, 8'h06, a, o);
        chk("R3 set second latch ack", 16'(a), 16'd1);
        do_stop(s);
        wr_byte(16'hFFFF, {wpen, wd, bp[1:0], 2'b00, bp[2]}, a, o);
        chk("R5 nv write ack", 16'(a), 16'd1);
        do_stop(s);
        chk("R5 nv start pulse", 16'(s), 16'd1);
        idle(NVC + 2);
        rd_reg(v);
        chk("R5 readback after nv write", 16'(v), 16'({wpen, wd, bp[1:0], 2'b01, bp[2]}));
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(v);
        chk("R1 reset register", 16'(v), 16'h00);
        chk("R1 R11 reset watchdog select", 16'(wd_sel_o), 16'd0);
        chk("R1 no start after reset", 16'(nv_start_o), 16'd0);
    endtask

    task automatic t_wel_gate();
        logic a, o, s;
        logic [7:0] v;
        wr_byte(16'h1234, 8'h5A, a, o);
        chk("R2 array write without latch ack", 16'(a), 16'd0);
        chk("R2 array write without latch permit", 16'(o), 16'd0);
        wr_byte(16'hFFFF, 8'h06, a, o);
        chk("R2 second latch without write latch", 16'(a), 16'd0);
        do_stop(s);
        wr_byte(16'hFFFF, 8'h40, a, o);
        chk("R2 other byte without latch", 16'(a), 16'd0);
        do_stop(s);
        rd_reg(v);
        chk("R2 register unchanged", 16'(v), 16'h00);
    endtask

    task automatic t_volatile();
        logic a, o, s;
        logic [7:0] v;
        wr_byte(16'hFFFF, 8'h02, a, o);
        chk("R3 set write latch ack", 16'(a), 16'd1);
        rd_reg(v);
        chk("R3 not applied before stop", 16'(v), 16'h00);
        do_stop(s);
        chk("R3 no start on volatile", 16'(s), 16'd0);
        rd_reg(v);
        chk("R3 R4 write latch readback", 16'(v), 16'h02);
        wr_byte(16'hFFFF, 8'h00, a, o);
        chk("R3 clear latch ack", 16'(a), 16'd1);
        do_stop(s);
        rd_reg(v);
        chk("R3 latch cleared", 16'(v), 16'h00);
        wr_byte(16'hFFFF, 8'h02, a, o);
        do_stop(s);
        wr_byte(16'hFFFF, 8'h80, a, o);
        chk("R5 nv byte without second latch", 16'(a), 16'd0);
        do_stop(s);
        chk("R5 no start without second latch", 16'(s), 16'd0);
        wr_byte(16'hFFFF, 8'h06, a, o);
        do_stop(s);
        chk("R3 no start on second latch", 16'(s), 16'd0);
        rd_reg(v);
        chk("R3 R4 both latches readback", 16'(v), 16'h06);
    endtask

    task automatic t_nv_busy();
        logic a, o, s;
        logic [7:0] v;
        wr_byte(16'hFFFF, 8'h48, a, o);
        chk("R5 nv write ack", 16'(a), 16'd1);
        @(negedge clk);
        chk("R12 ack lasts one cycle", 16'(ack_o), 16'd0);
        do_stop(s);
        chk("R5 start pulse", 16'(s), 16'd1);
        @(negedge clk);
        chk("R5 start pulse one cycle", 16'(nv_start_o), 16'd0);
        chk("R11 watchdog select", 16'(wd_sel_o), 16'd2);
        wr_byte(16'h0000, 8'h11, a, o);
        chk("R9 array write busy", 16'(a), 16'd0);
        wr_byte(16'hFFFF, 8'h02, a, o);
        chk("R9 register write busy", 16'(a), 16'd0);
        do_stop(s);
        rd_reg(v);
        chk("R9 R4 read during busy", 16'(v), 16'h4A);
        idle(NVC + 2);
        wr_byte(16'h0000, 8'h11, a, o);
        chk("R9 ack after busy", 16'(a), 16'd1);
        chk("R6 R12 permit unprotected", 16'(o), 16'd1);
        @(negedge clk);
        chk("R12 permit lasts one cycle", 16'(arr_wr_ok_o), 16'd0);
    endtask

    task automatic t_bp_sweep();
        logic [15:0] probe [18] = '{16'h0000, 16'h003F, 16'h0040, 16'h007F, 16'h0080,
                                    16'h00FF, 16'h0100, 16'h01FF, 16'h0200, 16'h1FFF,
                                    16'h2000, 16'h2FFF, 16'h3000, 16'h3FFF, 16'h4000,
                                    16'h7000, 16'hBFFF, 16'h8040};
        logic a, o;
        for (int b = 0; b < 8; b++) begin
            set_cfg(1'b0, 2'b00, 3'(b));
            for (int k = 0; k < 18; k++) begin
                wr_byte(probe[k], 8'hA5, a, o);
                // probes 14..17 alias through bits 15:14 (R7)
                chk((k >= 14) ? "R7 alias permit" : "R6 range permit",
                    16'(o), 16'(!prot_model(3'(b), probe[k])));
                chk("R6 range ack", 16'(a), 16'(!prot_model(3'(b), probe[k])));
            end
        end
        set_cfg(1'b0, 2'b00, 3'b000);
    endtask

    task automatic t_one_byte();
        logic a, o, s;
        logic [7:0] v;
        wr_byte(16'hFFFF, 8'h06, a, o);
        chk("R10 first register byte", 16'(a), 16'd1);
        wr_byte(16'hFFFF, 8'h06, a, o);
        chk("R10 second register byte", 16'(a), 16'd0);
        do_stop(s);
        rd_reg(v);
        chk("R10 first byte applied", 16'(v), 16'h06);
        wr_byte(16'hFFFF, 8'h00, a, o);
        do_stop(s);
        idle(NVC + 2);
        rd_reg(v);
        chk("R5 zero config written", 16'(v), 16'h02);
    endtask

    task automatic t_hw_lock();
        logic a, o, s;
        logic [7:0] v;
        wp_i = 1'b1;
        set_cfg(1'b1, 2'b01, 3'b001);
        rd_reg(v);
        chk("R8 pin alone does not lock", 16'(v), 16'hAA);
        wr_byte(16'hFFFF, 8'h06, a, o);
        chk("R8 second latch while locked", 16'(a), 16'd1);
        do_stop(s);
        rd_reg(v);
        chk("R8 second latch set", 16'(v), 16'hAE);
        wr_byte(16'hFFFF, 8'h00, a, o);
        chk("R8 nv write locked ack", 16'(a), 16'd0);
        do_stop(s);
        chk("R8 no start while locked", 16'(s), 16'd0);
        rd_reg(v);
        chk("R8 fields frozen", 16'(v), 16'hAE);
        chk("R8 R11 watchdog unchanged", 16'(wd_sel_o), 16'd1);
        wr_byte(16'h0100, 8'h33, a, o);
        chk("R8 unprotected array writable", 16'(o), 16'd1);
        wr_byte(16'h3000, 8'h33, a, o);
        chk("R8 protected array locked", 16'(o), 16'd0);
        wp_i = 1'b0;
        wr_byte(16'hFFFF, 8'h00, a, o);
        chk("R8 nv write after pin low", 16'(a), 16'd1);
        do_stop(s);
        chk("R8 start after pin low", 16'(s), 16'd1);
        idle(NVC + 2);
        rd_reg(v);
        chk("R8 protect-enable cleared", 16'(v), 16'h02);
    endtask

    task automatic t_wel_clear();
        logic a, o, s;
        logic [7:0] v;
        wr_byte(16'hFFFF, 8'h00, a, o);
        chk("R3 clear latch ack", 16'(a), 16'd1);
        do_stop(s);
        rd_reg(v);
        chk("R3 latch cleared", 16'(v), 16'h00);
        wr_byte(16'h0000, 8'h77, a, o);
        chk("R2 array locked after clear", 16'(a), 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst_n = 1'b0; addr_i = '0; wdata_i = '0;
        wr_i = 1'b0; rd_i = 1'b0; stop_i = 1'b0; wp_i = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_wel_gate();
        t_volatile();
        t_nv_busy();
        t_bp_sweep();
        t_one_byte();
        t_hw_lock();
        t_wel_clear();
        idle(2);
        summary();
    end

endmodule